// File: doc/BRIEF.md
# Upper Memory Window Router

This block decides where a memory request goes when its address lies in the 32-bit space. Addresses under a programmable top of low memory go to DRAM. Addresses from that boundary up to 4 GB go downstream to the PCI hierarchy by default. A set of programmable windows overrides that default. There are three fixed-size register windows, a 256 MB configuration window, two graphics windows that count only while internal graphics is enabled, and two PCIe base/limit windows (memory and prefetchable).

Each request presents an address with a valid strobe. One clock later the block returns a one-hot target select. For configuration hits it also returns the bus, device and function numbers taken from the address. When windows overlap, a fixed priority chooses the winner.

Top module: `upper_mem_router`

## Requirements
- R1: An address whose bits [31:20] are below `low_top` selects DRAM (`route_sel` bit 0), even when it also falls inside a programmed window.
- R2: An address at or above `low_top` that hits no enabled window selects the downstream route (`route_sel` bit 1).
- R3: The register windows are naturally aligned blocks of 2^EP_LG, 2^CTL_LG and 2^LNK_LG bytes. Each matches when its enable is high and the upper address bits equal its base. They select bits 2, 3 and 4, and when they overlap the lower bit wins.
- R4: The configuration window is the 256 MB block whose address bits [31:28] equal `cfg_base`, and it matches only while `cfg_en` is high. It selects bit 5 and reports bus = address [27:20], device = [19:15] and function = [14:12]. On every other route these three outputs are zero.
- R5: The graphics aperture (2^APER_LG bytes, bit 6) and the translation table (2^GTT_LG bytes, bit 7) match only while `gfx_en` is high.
- R6: The PCIe memory and prefetchable windows match when base ≤ address[31:20] ≤ limit, both ends inclusive at 1 MB granularity, and they select bit 8. A window whose limit is below its base never matches.
- R7: Overlapping windows resolve in this order: register windows, then the configuration window, then the graphics windows, then the PCIe windows, then the downstream route.
- R8: `route_valid` equals `req_valid` delayed by one clock, and the select and decoded fields belong to the address presented in that earlier cycle. While `route_valid` is low, `route_sel` is zero. While it is high, exactly one bit of `route_sel` is set.
- R9: While `rst_n` is low, `route_valid`, `route_sel`, `cfg_bus`, `cfg_dev` and `cfg_fn` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | Request byte address |
| low_top | input | 12 | Top of low DRAM, in MB |
| ep_en | input | 1 | Endpoint register window enable |
| ep_base | input | 32-EP_LG | Endpoint register window base, upper bits |
| ctl_en | input | 1 | Controller register window enable |
| ctl_base | input | 32-CTL_LG | Controller register window base, upper bits |
| lnk_en | input | 1 | Link register window enable |
| lnk_base | input | 32-LNK_LG | Link register window base, upper bits |
| cfg_en | input | 1 | Configuration window enable |
| cfg_base | input | 4 | Configuration window base, address bits [31:28] |
| gfx_en | input | 1 | Internal graphics enabled |
| aper_base | input | 32-APER_LG | Graphics aperture base, upper bits |
| gtt_base | input | 32-GTT_LG | Translation table base, upper bits |
| mem_base | input | 12 | PCIe memory window base, MB |
| mem_limit | input | 12 | PCIe memory window limit, MB |
| pf_base | input | 12 | PCIe prefetchable window base, MB |
| pf_limit | input | 12 | PCIe prefetchable window limit, MB |
| route_valid | output | 1 | Route result valid |
| route_sel | output | 9 | One-hot target select |
| cfg_bus | output | 8 | Bus number on configuration hit |
| cfg_dev | output | 5 | Device number on configuration hit |
| cfg_fn | output | 3 | Function number on configuration hit |

## Verification
The only state is a single result register, so any fault shows on the ports on the clock after the request. A wrong compare or priority term sets the wrong select bit, or more than one bit, in that cycle. A wrong field slice shows as bad bus, device or function numbers on a configuration hit, or as nonzero numbers on some other route. The vectors are placed at window edges, inside overlapping windows and inside disabled windows, so that an error by a single MB or a single priority step changes an observed select.

// File: rtl/upper_mem_router.sv
module upper_mem_router #(
  parameter int EP_LG   = 12,
  parameter int CTL_LG  = 14,
  parameter int LNK_LG  = 12,
  parameter int APER_LG = 28,
  parameter int GTT_LG  = 20,
  localparam int NT     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic [11:0]       low_top,
  input  logic              ep_en,
  input  logic [31:EP_LG]   ep_base,
  input  logic              ctl_en,
  input  logic [31:CTL_LG]  ctl_base,
  input  logic              lnk_en,
  input  logic [31:LNK_LG]  lnk_base,
  input  logic              cfg_en,
  input  logic [3:0]        cfg_base,
  input  logic              gfx_en,
  input  logic [31:APER_LG] aper_base,
  input  logic [31:GTT_LG]  gtt_base,
  input  logic [11:0]       mem_base,
  input  logic [11:0]       mem_limit,
  input  logic [11:0]       pf_base,
  input  logic [11:0]       pf_limit,
  output logic              route_valid,
  output logic [NT-1:0]     route_sel,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn
);

  localparam int T_DRAM = 0, T_DOWN = 1, T_EP = 2, T_CTL = 3, T_LNK = 4,
                 T_CFG = 5, T_APER = 6, T_GTT = 7, T_PCIE = 8;

  logic [11:0] mb;
  logic below, hit_ep, hit_ctl, hit_lnk, hit_cfg, hit_aper, hit_gtt, hit_mem, hit_pf;
  logic [NT-1:0] nxt_sel;
  logic unused_lo;

  assign mb       = req_addr[31:20];
  assign below    = mb < low_top;
  assign hit_ep   = ep_en  && req_addr[31:EP_LG]  == ep_base;
  assign hit_ctl  = ctl_en && req_addr[31:CTL_LG] == ctl_base;
  assign hit_lnk  = lnk_en && req_addr[31:LNK_LG] == lnk_base;
  assign hit_cfg  = cfg_en && req_addr[31:28] == cfg_base;
  assign hit_aper = gfx_en && req_addr[31:APER_LG] == aper_base;
  assign hit_gtt  = gfx_en && req_addr[31:GTT_LG]  == gtt_base;
  assign hit_mem  = (mb >= mem_base) && (mb <= mem_limit);
  assign hit_pf   = (mb >= pf_base)  && (mb <= pf_limit);
  assign unused_lo = ^req_addr[11:0];

  always_comb begin
    nxt_sel = '0;
    if (below)                   nxt_sel[T_DRAM] = 1'b1;
    else if (hit_ep)             nxt_sel[T_EP]   = 1'b1;
    else if (hit_ctl)            nxt_sel[T_CTL]  = 1'b1;
    else if (hit_lnk)            nxt_sel[T_LNK]  = 1'b1;
    else if (hit_cfg)            nxt_sel[T_CFG]  = 1'b1;
    else if (hit_aper)           nxt_sel[T_APER] = 1'b1;
    else if (hit_gtt)            nxt_sel[T_GTT]  = 1'b1;
    else if (hit_mem || hit_pf)  nxt_sel[T_PCIE] = 1'b1;
    else                         nxt_sel[T_DOWN] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_valid <= 1'b0;
      route_sel   <= '0;
      {cfg_bus, cfg_dev, cfg_fn} <= '0;
    end else begin
      route_valid <= req_valid;
      route_sel   <= req_valid ? nxt_sel : '0;
      {cfg_bus, cfg_dev, cfg_fn} <= (req_valid && nxt_sel[T_CFG]) ? req_addr[27:12] : 16'h0;
    end
  end

  // R8: exactly one target while valid, none while idle
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> $countones(route_sel) == 1);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !route_valid |-> route_sel == '0);
  // R1: DRAM only below the boundary, and always below it
  a_r1_dram: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && route_sel[T_DRAM] |-> $past(req_addr[31:20]) < $past(low_top));
  a_r1_below: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && ($past(req_addr[31:20]) < $past(low_top)) |-> route_sel[T_DRAM]);
  // R5: graphics targets need graphics enabled
  a_r5_gfx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && (route_sel[T_APER] || route_sel[T_GTT]) |-> $past(gfx_en));
  // R6: PCIe target only inside an inclusive window
  a_r6_pcie_win: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid && route_sel[T_PCIE] |->
      ($past(req_addr[31:20]) >= $past(mem_base) && $past(req_addr[31:20]) <= $past(mem_limit)) ||
      ($past(req_addr[31:20]) >= $past(pf_base)  && $past(req_addr[31:20]) <= $past(pf_limit)));
  // R4: decoded fields are zero off the configuration route
  a_r4_bdf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !route_sel[T_CFG] |-> {cfg_bus, cfg_dev, cfg_fn} == 16'h0);
  // R9: reset state
  always_ff @(posedge clk) begin
    if (!rst_n) a_r9_reset: assert (!route_valid && route_sel == '0);
  end

endmodule

// File: tb/upper_mem_router_bench.sv
module upper_mem_router_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, ep_en, ctl_en, lnk_en, cfg_en, gfx_en;
  logic [31:0] req_addr;
  logic [11:0] low_top, mem_base, mem_limit, pf_base, pf_limit;
  logic [31:12] ep_base;
  logic [31:14] ctl_base;
  logic [31:12] lnk_base;
  logic [3:0]  cfg_base;
  logic [31:28] aper_base;
  logic [31:20] gtt_base;
  logic route_valid;
  logic [8:0] route_sel;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;

  upper_mem_router u_upper_mem_router (.*);

  int runs = 0, fails = 0;

  localparam logic [31:0] EP_A = 32'hFED1_9000, CTL_A = 32'hFED1_4000, LNK_A = 32'hFED1_8000;
  localparam logic [31:0] GTT_A = 32'hCFF0_0000;

  // {addr, expected select, expected bus/dev/fn}
  localparam logic [56:0] VEC [16] = '{
    {32'h0000_1000, 9'h001, 16'h0000},  // R1
    {32'h3FFF_FFFF, 9'h001, 16'h0000},  // R1 edge
    {32'h4000_0000, 9'h002, 16'h0000},  // R2 edge
    {32'h8000_0000, 9'h100, 16'h0000},  // R6 base
    {32'h8FFF_FFFF, 9'h100, 16'h0000},  // R6 limit
    {32'h9000_0000, 9'h002, 16'h0000},  // R2 past limit
    {32'hA123_4567, 9'h100, 16'h0000},  // R6 prefetch
    {32'hBFFF_FFFC, 9'h100, 16'h0000},  // R6 prefetch limit
    {32'hE12A_B000, 9'h020, 16'h12AB},  // R4
    {32'hFED1_9FFF, 9'h004, 16'h0000},  // R3
    {32'hFED1_4ABC, 9'h008, 16'h0000},  // R3
    {32'hFED1_8000, 9'h010, 16'h0000},  // R3
    {32'hFED1_A000, 9'h002, 16'h0000},  // R2
    {32'hD800_0000, 9'h040, 16'h0000},  // R5
    {32'hCFF0_0010, 9'h080, 16'h0000},  // R5
    {32'hFFFF_FFFF, 9'h002, 16'h0000}   // R2
  };

  task automatic defaults();
    low_top = 12'h400;
    ep_en = 1; ctl_en = 1; lnk_en = 1; cfg_en = 1; gfx_en = 1;
    ep_base = EP_A[31:12]; ctl_base = CTL_A[31:14]; lnk_base = LNK_A[31:12];
    cfg_base = 4'hE; aper_base = 4'hD; gtt_base = GTT_A[31:20];
    mem_base = 12'h800; mem_limit = 12'h8FF; pf_base = 12'hA00; pf_limit = 12'hBFF;
  endtask

  task automatic route(input string tag, input logic [31:0] a, input logic [8:0] es, input logic [15:0] eb);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    runs++;
    if (route_valid !== 1'b1 || route_sel !== es || {cfg_bus, cfg_dev, cfg_fn} !== eb) begin
      fails++;
      $display("FAIL %s addr=%h: valid=%b sel=%h bdf=%h, expected valid=1 sel=%h bdf=%h",
               tag, a, route_valid, route_sel, {cfg_bus, cfg_dev, cfg_fn}, es, eb);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 1; req_addr = 32'hE12A_B000;
    defaults();
    repeat (3) @(negedge clk);
    runs++;
    if (route_valid !== 0 || route_sel !== 0 || {cfg_bus, cfg_dev, cfg_fn} !== 0) begin
      fails++;
      $display("FAIL R9 reset: valid=%b sel=%h bdf=%h, expected 0/0/0",
               route_valid, route_sel, {cfg_bus, cfg_dev, cfg_fn});
    end
    req_valid = 0;
    @(negedge clk) rst_n = 1;

    foreach (VEC[i]) route($sformatf("R8 vector %0d", i), VEC[i][56:25], VEC[i][24:16], VEC[i][15:0]);

    @(negedge clk);
    runs++;
    if (route_valid !== 0 || route_sel !== 0) begin
      fails++;
      $display("FAIL R8 idle: valid=%b sel=%h, expected 0/000", route_valid, route_sel);
    end

    gfx_en = 0;
    route("R5 aperture off", 32'hD800_0000, 9'h002, 16'h0);
    route("R5 table off", 32'hCFF0_0010, 9'h002, 16'h0);
    defaults();
    ep_en = 0;
    route("R3 disabled window", 32'hFED1_9000, 9'h002, 16'h0);
    defaults();
    pf_base = 12'hB00; pf_limit = 12'hA00;
    route("R6 inverted window", 32'hA800_0000, 9'h002, 16'h0);
    defaults();
    mem_base = 12'h900; mem_limit = 12'h900;
    route("R6 one MB window", 32'h900F_FFFF, 9'h100, 16'h0);
    route("R6 one MB window end", 32'h9010_0000, 9'h002, 16'h0);
    defaults();
    cfg_en = 0;
    route("R4 config disabled", 32'hE12A_B000, 9'h002, 16'h0);
    defaults();
    ep_base = 20'hE0000;
    route("R7 register over config", 32'hE000_0000, 9'h004, 16'h0);
    defaults();
    ctl_base = EP_A[31:14];
    route("R3 endpoint over controller", 32'hFED1_9000, 9'h004, 16'h0);
    defaults();
    aper_base = 4'hE;
    route("R7 config over graphics", 32'hE000_5000, 9'h020, 16'h0005);
    defaults();
    mem_base = 12'hD00; mem_limit = 12'hDFF;
    route("R7 graphics over pcie", 32'hD800_0000, 9'h040, 16'h0);
    defaults();
    mem_base = 12'h000; mem_limit = 12'h0FF;
    route("R1 dram over window", 32'h0010_0000, 9'h001, 16'h0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule